// File: doc/BRIEF.md
# Key-Protected Slow Clock Selector

This block produces the slow (nominally 32 kHz) tick that paces a real-time clock. Two single-cycle tick streams arrive in the system clock domain: one from an internal RC oscillator and one from an external crystal. A small state machine records which of the two is in use. On the internal path the ticks are first divided by a fixed prescaler (a parameter, 32 by default, 1 meaning none) and then by a programmable factor N+1. On the external path the crystal ticks pass straight through. A second output repeats the slow tick only while a pin gate bit is set.

The source selection is guarded: a write to the control word changes the selection only when its upper half carries the unlock key 0x16AA. Software therefore cannot flip the clock source by accident with a stray store. Whenever the source changes or the divide factor is rewritten, both divider counters restart. The first internal tick after such a change therefore comes after a full period.

The source state machine has two states, `SRC_INTERNAL` (the reset state) and `SRC_EXTERNAL`. It has two transitions. `GO_EXTERNAL` is an unlocked control write with bit 0 set, taken from `SRC_INTERNAL`. `GO_INTERNAL` is an unlocked control write with bit 0 clear, taken from `SRC_EXTERNAL`. Any other write leaves the state where it is.

Top module: `sck_slow_clk_sel`

## Requirements
- R1: After reset the internal source is selected, N is 0, the pin gate is off, and `slow_tick` and `pin_tick` are low.
- R2: A write to offset 0x00 whose bits [31:16] equal 0x16AA sets the source from bit 0 (1 external, 0 internal). A write to 0x00 with any other upper half leaves the source unchanged.
- R3: A read of offset 0x00 returns the current source in bit 0 and zero in bits [31:1], so the key never reads back.
- R4: With the internal source selected, `slow_tick` pulses once for every PRESCALE*(N+1) internal ticks. The pulse comes in the cycle after the internal tick that completes the period.
- R5: N is taken from bits [4:0] of a write to offset 0x08. A read of 0x08 returns N in bits [4:0] and zero elsewhere.
- R6: With the external source selected, `slow_tick` equals `ext_tick` delayed by one cycle, and internal ticks have no effect on it.
- R7: A source change or any write to offset 0x08 restarts both divider counters. No slow tick comes out of that cycle, and the next internal tick arrives after a full period.
- R8: Bit 0 of offset 0x60 is the pin gate. `pin_tick` follows the slow tick when the gate in force is 1 and is low otherwise. The gate reads back in bit 0 with zero above it.
- R9: Writes to other offsets change nothing, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| int_tick | input | 1 | One-cycle tick from the internal RC oscillator |
| ext_tick | input | 1 | One-cycle tick from the external crystal |
| slow_tick | output | 1 | Selected and divided slow tick |
| pin_tick | output | 1 | Slow tick gated for the output pin |

## Verification
Some rules are checked on every cycle. On the external path the output copies the crystal tick one cycle later. On the internal path a slow tick can only follow an internal tick. A restart cycle never emits a tick. A closed gate keeps the pin low. An unkeyed control write never moves the source. The control word reads back with a zero key field. The exact internal period of PRESCALE*(N+1) ticks, and the full first period after a restart, can only be shown by the bench's reference model as random tick patterns, keyed and unkeyed writes and divider rewrites go by.

// File: rtl/sck_pkg.sv
package sck_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int NDIV_W  = 5;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_NDIV = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_GATE = 8'h60;

    localparam logic [DATA_W/2-1:0] UNLOCK_KEY = 16'h16AA;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } src_e;
endpackage

// File: rtl/sck_regs.sv
module sck_regs
    import sck_pkg::*;
#(
    parameter logic [DATA_W/2-1:0] KEY = UNLOCK_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sel_ext,
    output logic [DATA_W-1:0] rdata,
    output logic              ctrl_ok,
    output logic              want_ext,
    output logic              ndiv_wr,
    output logic [NDIV_W-1:0] ndiv,
    output logic              gate_en
);
    localparam int KEY_LSB = DATA_W / 2;

    logic gate_wr;

    // key check: only the upper half decides whether a control write lands
    assign ctrl_ok  = wr && (addr == OFF_CTRL) && (wdata[DATA_W-1:KEY_LSB] == KEY);
    assign want_ext = wdata[0];
    assign ndiv_wr  = wr && (addr == OFF_NDIV);
    assign gate_wr  = wr && (addr == OFF_GATE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ndiv    <= '0;
            gate_en <= 1'b0;
        end else begin
            if (ndiv_wr) ndiv    <= wdata[NDIV_W-1:0];
            if (gate_wr) gate_en <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_CTRL: rdata[0]          = sel_ext;
            OFF_NDIV: rdata[NDIV_W-1:0] = ndiv;
            OFF_GATE: rdata[0]          = gate_en;
            default:  rdata             = '0;
        endcase
    end
endmodule

// File: rtl/sck_src_fsm.sv
module sck_src_fsm
    import sck_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_ok,
    input  logic want_ext,
    output logic sel_ext,
    output logic src_change
);
    src_e state_q, state_d;

    // next-state logic: GO_EXTERNAL / GO_INTERNAL on an unlocked write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_INTERNAL: if (ctrl_ok && want_ext)  state_d = SRC_EXTERNAL;
            SRC_EXTERNAL: if (ctrl_ok && !want_ext) state_d = SRC_INTERNAL;
            default:      state_d = SRC_INTERNAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_INTERNAL;
        else        state_q <= state_d;
    end

    always_comb begin
        sel_ext    = (state_q == SRC_EXTERNAL);
        src_change = (state_d != state_q);
    end
endmodule

// File: rtl/sck_divider.sv
module sck_divider
    import sck_pkg::*;
#(
    parameter int PRESCALE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick_in,
    input  logic              restart,
    input  logic [NDIV_W-1:0] ndiv,
    output logic              tick_out
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic pre_done;
    logic [NDIV_W-1:0] div_q;

    generate
        if (PRESCALE > 1) begin : g_pre
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
            logic [PRE_W-1:0] pre_q;
            assign pre_done = run && tick_in && (pre_q == PRE_LAST);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)               pre_q <= '0;
                else if (restart)         pre_q <= '0;
                else if (run && tick_in)  pre_q <= pre_done ? '0 : pre_q + 1'b1;
            end
        end else begin : g_nopre
            assign pre_done = run && tick_in;
        end
    endgenerate

    assign tick_out = pre_done && (div_q == ndiv) && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        div_q <= '0;
        else if (restart)  div_q <= '0;
        else if (pre_done) div_q <= (div_q == ndiv) ? '0 : div_q + 1'b1;
    end
endmodule

// File: rtl/sck_slow_clk_sel.sv
module sck_slow_clk_sel
    import sck_pkg::*;
#(
    parameter int                  PRESCALE = 32,
    parameter logic [DATA_W/2-1:0] KEY      = UNLOCK_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              int_tick,
    input  logic              ext_tick,
    output logic              slow_tick,
    output logic              pin_tick
);
    logic              ctrl_ok, want_ext, ndiv_wr, gate_en;
    logic              sel_ext, src_change, restart, div_tick, slow_d;
    logic [NDIV_W-1:0] ndiv;

    sck_regs #(.KEY(KEY)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .sel_ext(sel_ext), .rdata(reg_rdata),
        .ctrl_ok(ctrl_ok), .want_ext(want_ext), .ndiv_wr(ndiv_wr),
        .ndiv(ndiv), .gate_en(gate_en)
    );

    sck_src_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_ok(ctrl_ok), .want_ext(want_ext),
        .sel_ext(sel_ext), .src_change(src_change)
    );

    assign restart = src_change || ndiv_wr;

    sck_divider #(.PRESCALE(PRESCALE)) u_div (
        .clk(clk), .rst_n(rst_n), .run(!sel_ext), .tick_in(int_tick),
        .restart(restart), .ndiv(ndiv), .tick_out(div_tick)
    );

    assign slow_d = restart ? 1'b0 : (sel_ext ? ext_tick : div_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_tick <= 1'b0;
            pin_tick  <= 1'b0;
        end else begin
            slow_tick <= slow_d;
            pin_tick  <= slow_d && gate_en;
        end
    end
endmodule

// File: rtl/sck_slow_clk_sel_chk.sv
module sck_slow_clk_sel_chk
    import sck_pkg::*;
#(
    parameter logic [DATA_W/2-1:0] KEY = UNLOCK_KEY
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              int_tick,
    input logic              ext_tick,
    input logic              slow_tick,
    input logic              pin_tick,
    input logic              sel_ext,
    input logic              restart,
    input logic              gate_en
);
    assert_locked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CTRL && reg_wdata[DATA_W-1:DATA_W/2] != KEY) |=> $stable(sel_ext));

    assert_ctrl_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_CTRL) |-> (reg_rdata == {{(DATA_W-1){1'b0}}, sel_ext}));

    assert_int_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ext && !int_tick) |=> !slow_tick);

    assert_ext_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ext && ext_tick && !restart) |=> slow_tick);

    assert_ext_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ext && !ext_tick) |=> !slow_tick);

    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !slow_tick);

    assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> !pin_tick);
endmodule

bind sck_slow_clk_sel sck_slow_clk_sel_chk #(.KEY(KEY)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_tick(int_tick),
    .ext_tick(ext_tick), .slow_tick(slow_tick), .pin_tick(pin_tick),
    .sel_ext(sel_ext), .restart(restart), .gate_en(gate_en)
);

// File: tb/sim_sck_slow_clk_sel.sv
`timescale 1ns/1ps
module sim_sck_slow_clk_sel;
    localparam int PRE = 32;
    localparam logic [15:0] KEYV = 16'h16AA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        int_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        slow_tick, pin_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    bit       m_sel = 0, m_gate = 0;
    int       m_n = 0, m_pre = 0, m_div = 0;
    bit       e_slow = 0, e_pin = 0;
    bit       e_restart = 0;

    always #2.5 clk = ~clk;

    sck_slow_clk_sel #(.PRESCALE(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_tick(int_tick),
        .ext_tick(ext_tick), .slow_tick(slow_tick), .pin_tick(pin_tick)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return {31'b0, m_sel};
            8'h08:   return 32'(m_n);
            8'h60:   return {31'b0, m_gate};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_req(input logic [7:0] a);
        case (a)
            8'h00:   return "R3";
            8'h08:   return "R5";
            8'h60:   return "R8";
            default: return "R9";
        endcase
    endfunction

    // one cycle: check registered outputs, drive inputs, check read, advance model
    task automatic step(input bit it, input bit et, input bit wr,
                        input logic [7:0] a, input logic [31:0] wd);
        bit restart, pulse, key_ok;
        @(negedge clk);
        check(slow_tick == e_slow, e_restart ? "R7" : (m_sel ? "R6" : "R4"), slow_tick, e_slow);
        check(pin_tick == e_pin, "R8", pin_tick, e_pin);
        int_tick = it; ext_tick = et; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        check(reg_rdata == exp_read(a), read_req(a), reg_rdata, exp_read(a));
        key_ok  = wr && a == 8'h00 && wd[31:16] == KEYV;
        restart = (key_ok && wd[0] != m_sel) || (wr && a == 8'h08);
        pulse   = !m_sel && it && (m_pre == PRE-1) && (m_div == m_n);
        e_slow  = restart ? 1'b0 : (m_sel ? et : pulse);
        e_pin   = e_slow && m_gate;
        e_restart = restart;
        if (restart) begin
            m_pre = 0; m_div = 0;
        end else if (!m_sel && it) begin
            if (m_pre == PRE-1) begin
                m_pre = 0;
                m_div = (m_div == m_n) ? 0 : m_div + 1;
            end else m_pre++;
        end
        if (key_ok) m_sel = wd[0];
        if (wr && a == 8'h08) m_n = int'(wd[4:0]);
        if (wr && a == 8'h60) m_gate = wd[0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd5150);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(slow_tick == 0 && pin_tick == 0, "R1", {slow_tick, pin_tick}, 0);
        reg_addr = 8'h00; #1 check(reg_rdata == 0, "R1", reg_rdata, 0);
        reg_addr = 8'h08; #1 check(reg_rdata == 0, "R1", reg_rdata, 0);
        reg_addr = 8'h60; #1 check(reg_rdata == 0, "R1", reg_rdata, 0);
        rst_n = 1'b1;

        // R2 wrong key must not switch; R9 unmapped write ignored
        step(0, 0, 1, 8'h00, 32'h16AB_0001);
        step(0, 0, 0, 8'h00, 0);
        check(reg_rdata[0] == 1'b0, "R2", reg_rdata, 0);
        step(0, 0, 1, 8'h24, 32'hFFFF_FFFF);
        step(0, 0, 0, 8'h24, 0);
        // R4 with N=0: continuous internal ticks, one slow tick per PRE
        step(0, 0, 1, 8'h60, 32'h1);
        for (int i = 0; i < 3*PRE + 4; i++) step(1, 0, 0, 8'h60, 0);
        // R5 max N, upper bits ignored
        step(0, 0, 1, 8'h08, 32'hFFFF_FFFF);
        for (int i = 0; i < 2*PRE*32 + 8; i++) step(1, 1, 0, 8'h08, 0);
        // R7 rewrite N mid-period then full period
        step(1, 0, 1, 8'h08, 32'h2);
        for (int i = 0; i < 5*PRE; i++) step(1, 0, 0, 8'h08, 0);
        // R2 keyed switch to external, R6 passthrough
        step(1, 1, 1, 8'h00, {KEYV, 16'h0001});
        step(0, 0, 0, 8'h00, 0);
        check(reg_rdata == 32'h1, "R2", reg_rdata, 1);
        for (int i = 0; i < 64; i++) step(1, 1'($urandom % 2), 0, 8'h00, 0);
        // R8 gate off
        step(0, 1, 1, 8'h60, 32'h0);
        for (int i = 0; i < 16; i++) step(0, 1, 0, 8'h60, 0);
        // back to internal: restart then full period
        step(1, 1, 1, 8'h00, {KEYV, 16'h0000});
        step(0, 0, 1, 8'h60, 32'h1);

        // constrained random mix
        for (int i = 0; i < 60000; i++) begin
            logic [7:0]  a;
            logic [31:0] wd;
            bit wr;
            case ($urandom % 4)
                0: a = 8'h00; 1: a = 8'h08; 2: a = 8'h60; default: a = 8'h24;
            endcase
            wr = ($urandom % 300) == 0;
            wd = $urandom;
            if (a == 8'h00 && ($urandom % 2)) wd[31:16] = KEYV;
            if (a == 8'h08) wd[4:0] = 5'($urandom % 4);
            step(1'(($urandom % 4) != 0), 1'(($urandom % 3) == 0), wr, a, wd);
        end
        step(0, 0, 0, 8'h00, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule